// File: doc/BRIEF.md
# Shared Reset Pin Controller

This block owns one multi-function package pin that starts life as a plain general-purpose input and can be turned, once, into an active-low external reset line. After the switch the pin is an open-drain line with its pull-up on; an outside low level on it resets the chip, and every reset that the chip raises for itself (other than power-on) pulls the line low for a fixed number of bus cycles. This lets the rest of the board see the reset.

The block also decides why each reset happened. It keeps a status word that holds exactly one cause bit. Power-on and low-voltage events return the pin to its input role. Watchdog, illegal-opcode and debug-force requests come in as single-cycle pulses. An illegal-opcode reset is raised when a stop request arrives while stop is disabled. The pin level is sampled through a synchronizer. The block's own outbound low pulse is masked, so it can never be taken for an external reset.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `por` is high, `sys_rst` is 1. After `por` falls, the pin is in input role (`ctl_rd`=0, `pin_pullup`=0, `pin_drive_low`=0) and `rst_status` equals 6'b000001.
- R2: A cycle with `wr_en`=1 and `wr_data`=1 switches the pin to reset role. From the next cycle `ctl_rd` reads 1 and `pin_pullup` is 1. A write of 0 while in input role leaves `ctl_rd` at 0.
- R3: Once in reset role, writes of 0 are ignored and `ctl_rd` keeps reading 1. Only `por` or an accepted low-voltage reset returns the pin to input role.
- R4: An accepted non-power-on reset raises `sys_rst` in the cycle after the request edge and holds it for exactly STRETCH_CYCLES (default 34) cycles. When the pin is in reset role, `pin_drive_low` is 1 for the same cycles, and otherwise it stays 0.
- R5: In reset role, a low level on `pin_in` passes a SYNC_STAGES (default 2) flop synchronizer and is accepted on the following edge, so `sys_rst` rises three edges after the first low sample. In input role a low `pin_in` causes no reset.
- R6: `rst_status` always has exactly one bit set: bit 0 power-on, bit 1 low-voltage, bit 2 external pin, bit 3 watchdog, bit 4 illegal opcode, bit 5 debug force. When requests coincide, the lowest-numbered bit wins, and older bits are cleared.
- R7: A stop request with `stop_en`=0 causes an illegal-opcode reset (bit 4). With `stop_en`=1 it causes no reset and leaves `rst_status` unchanged.
- R8: From the accepting edge until SYNC_STAGES+1 cycles after `sys_rst` falls, new requests are ignored. The outbound low pulse is never logged as a pin reset.
- R9: A low-voltage reset returns the pin to input role, so its window has no outbound drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| lvd_req | input | 1 | Low-voltage reset request pulse |
| wdog_req | input | 1 | Watchdog reset request pulse |
| dbg_req | input | 1 | Debug force reset request pulse |
| stop_exec | input | 1 | Stop request pulse from the core |
| stop_en | input | 1 | Stop mode allowed |
| pin_in | input | 1 | Level seen on the shared pin |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 1 | Value written to the pin role bit |
| ctl_rd | output | 1 | Read-back of the pin role bit |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the pin |
| pin_pullup | output | 1 | Pin pull-up enable |
| sys_rst | output | 1 | System reset to the chip |
| rst_status | output | 6 | One-hot reset cause word |

## Verification
Several rules are checked by assertions on every cycle:
- the one-hot status word;
- the role bit that cannot be cleared by writes;
- pull-down drive only in reset role;
- the status word holding still while a window or guard is running;
- the illegal-opcode and allowed-stop outcomes.

The exact 34-cycle length of the window, the synchronizer latency of an outside low, the priority of coinciding requests and the masking of the block's own pulse can only be shown by the bench scenarios. These scenarios drive the pin through an open-drain model and count cycles at the ports.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;
   localparam int CAUSE_W  = 6;
   localparam int IDX_POR  = 0;
   localparam int IDX_LVD  = 1;
   localparam int IDX_PIN  = 2;
   localparam int IDX_WDOG = 3;
   localparam int IDX_ILOP = 4;
   localparam int IDX_DBG  = 5;
   typedef logic [CAUSE_W-1:0] cause_vec_t;
endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstpin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '1;
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstpin_cause.sv
module rstpin_cause
   import rstpin_pkg::*;
(
   input  logic                 clk,
   input  logic                 por,
   input  logic                 busy,
   input  logic [CAUSE_W-1:1]   req,
   output logic                 accept,
   output logic                 lvd_hit,
   output cause_vec_t           status
);
   cause_vec_t pick;

   always_comb begin
      pick = '0;
      for (int i = CAUSE_W - 1; i >= 1; i--) begin
         if (req[i]) pick = cause_vec_t'(1) << i;
      end
   end

   assign accept  = !busy && (|req);
   assign lvd_hit = accept && req[IDX_LVD];

   always_ff @(posedge clk or posedge por) begin
      if (por)         status <= cause_vec_t'(1) << IDX_POR;
      else if (accept) status <= pick;
   end

   AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (por)
      $countones(status) == 1);                                    // R6
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (por)
      busy |=> $stable(status));                                   // R8
endmodule

// File: rtl/rstpin_stretch.sv
module rstpin_stretch #(
   parameter int STRETCH = 34,
   parameter int GUARD   = 3
) (
   input  logic clk,
   input  logic por,
   input  logic start,
   output logic busy,
   output logic active
);
   localparam int TOTAL = STRETCH + GUARD;
   localparam int CNT_W = $clog2(TOTAL + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or posedge por) begin
      if (por)             cnt <= '0;
      else if (start)      cnt <= CNT_W'(TOTAL);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy   = (cnt != '0);
   assign active = (cnt > CNT_W'(GUARD));

   AST_START_IDLE: assert property (@(posedge clk) disable iff (por)
      start |-> !busy);                                            // R8
   AST_START_ACTIVE: assert property (@(posedge clk) disable iff (por)
      start |=> active);                                           // R4
   AST_GUARD_FOLLOWS: assert property (@(posedge clk) disable iff (por)
      $fell(active) |-> busy);                                     // R8
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
   import rstpin_pkg::*;
#(
   parameter int STRETCH_CYCLES = 34,
   parameter int SYNC_STAGES    = 2
) (
   input  logic               clk,
   input  logic               por,
   input  logic               lvd_req,
   input  logic               wdog_req,
   input  logic               dbg_req,
   input  logic               stop_exec,
   input  logic               stop_en,
   input  logic               pin_in,
   input  logic               wr_en,
   input  logic               wr_data,
   output logic               ctl_rd,
   output logic               pin_drive_low,
   output logic               pin_pullup,
   output logic               sys_rst,
   output logic [CAUSE_W-1:0] rst_status
);
   localparam int GUARD_CYCLES = SYNC_STAGES + 1;

   generate
      if (STRETCH_CYCLES < 1) begin : g_bad_stretch
         $error("rstpin_ctrl: STRETCH_CYCLES must be at least 1");
      end
   endgenerate

   logic pin_en;
   logic pin_q;
   logic busy, active, accept, lvd_hit;
   logic [CAUSE_W-1:1] req;

   rstpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst(por), .d(pin_in), .q(pin_q)
   );

   always_comb begin
      req           = '0;
      req[IDX_LVD]  = lvd_req;
      req[IDX_PIN]  = pin_en && !pin_q;
      req[IDX_WDOG] = wdog_req;
      req[IDX_ILOP] = stop_exec && !stop_en;
      req[IDX_DBG]  = dbg_req;
   end

   rstpin_cause u_cause (
      .clk(clk), .por(por), .busy(busy), .req(req),
      .accept(accept), .lvd_hit(lvd_hit), .status(rst_status)
   );

   rstpin_stretch #(.STRETCH(STRETCH_CYCLES), .GUARD(GUARD_CYCLES)) u_stretch (
      .clk(clk), .por(por), .start(accept), .busy(busy), .active(active)
   );

   always_ff @(posedge clk or posedge por) begin
      if (por)                    pin_en <= 1'b0;
      else if (lvd_hit)           pin_en <= 1'b0;
      else if (wr_en && wr_data)  pin_en <= 1'b1;
   end

   assign ctl_rd        = pin_en;
   assign pin_pullup    = pin_en;
   assign pin_drive_low = active && pin_en;
   assign sys_rst       = por || active;

   AST_DRIVE_NEEDS_ROLE: assert property (@(posedge clk) disable iff (por)
      pin_drive_low |-> ctl_rd);                                   // R4
   AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (por)
      (ctl_rd && !lvd_req) |=> ctl_rd);                            // R3
   AST_ILOP_LOGGED: assert property (@(posedge clk) disable iff (por)
      (!busy && stop_exec && !stop_en && !lvd_req && !wdog_req && pin_q)
      |=> rst_status[IDX_ILOP]);                                   // R7
   AST_STOP_ALLOWED: assert property (@(posedge clk) disable iff (por)
      (!busy && stop_exec && stop_en && !lvd_req && !wdog_req && !dbg_req
       && !(pin_en && !pin_q)) |=> !sys_rst);                      // R7
endmodule

// File: tb/sim_rstpin_ctrl.sv
`timescale 1ns/100ps
module sim_rstpin_ctrl;
   localparam int STRETCH = 34;
   localparam int SYNC    = 2;
   localparam int GUARD   = SYNC + 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por = 1'b1;
   logic lvd_req = 0, wdog_req = 0, dbg_req = 0, stop_exec = 0, stop_en = 0;
   logic wr_en = 0, wr_data = 0, ext_low = 0;
   logic pin_in, ctl_rd, pin_drive_low, pin_pullup, sys_rst;
   logic [5:0] rst_status;

   assign pin_in = !(ext_low || pin_drive_low);

   rstpin_ctrl #(.STRETCH_CYCLES(STRETCH), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .por(por), .lvd_req(lvd_req), .wdog_req(wdog_req),
      .dbg_req(dbg_req), .stop_exec(stop_exec), .stop_en(stop_en),
      .pin_in(pin_in), .wr_en(wr_en), .wr_data(wr_data), .ctl_rd(ctl_rd),
      .pin_drive_low(pin_drive_low), .pin_pullup(pin_pullup),
      .sys_rst(sys_rst), .rst_status(rst_status)
   );

   int errs = 0, checks = 0;
   bit done = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_por();
      @(negedge clk) por = 1'b1;
      repeat (3) @(negedge clk);
      chk(sys_rst == 1'b1, "R1 sys_rst during por", sys_rst, 1);
      por = 1'b0;
      @(negedge clk);
      chk(rst_status == 6'b000001, "R1 status after por", rst_status, 1);
      chk(ctl_rd == 1'b0, "R1 role after por", ctl_rd, 0);
      chk(pin_pullup == 1'b0, "R1 pullup after por", pin_pullup, 0);
      chk(pin_drive_low == 1'b0, "R1 drive after por", pin_drive_low, 0);
      chk(sys_rst == 1'b0, "R1 sys_rst after por", sys_rst, 0);
   endtask

   task automatic write_role(bit v);
      @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
      @(negedge clk) begin wr_en = 1'b0; wr_data = 1'b0; end
   endtask

   // drive one request cycle; returns at the negedge after the accepting edge
   task automatic pulse(bit lv, bit wd, bit st, bit se, bit db);
      @(negedge clk) begin
         lvd_req = lv; wdog_req = wd; stop_exec = st; stop_en = se; dbg_req = db;
      end
      @(negedge clk) begin
         lvd_req = 0; wdog_req = 0; stop_exec = 0; stop_en = 0; dbg_req = 0;
      end
   endtask

   task automatic measure(output int rst_n, output int drv_n);
      int w = 0;
      while (!sys_rst && w < 6) begin @(negedge clk); w++; end
      rst_n = 0; drv_n = 0;
      while (sys_rst && rst_n < 200) begin
         rst_n++;
         if (pin_drive_low) drv_n++;
         @(negedge clk);
      end
      repeat (GUARD + 1) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int rn, dn;
      do_por();

      // watchdog in input role: window with no drive
      pulse(0, 1, 0, 0, 0);
      chk(sys_rst == 1'b1, "R4 latency", sys_rst, 1);
      measure(rn, dn);
      chk(rn == STRETCH, "R4 window length", rn, STRETCH);
      chk(dn == 0, "R4 no drive in input role", dn, 0);
      chk(rst_status == 6'b001000, "R6 watchdog bit", rst_status, 8);

      // low pin in input role ignored
      @(negedge clk) ext_low = 1'b1;
      repeat (6) @(negedge clk);
      chk(sys_rst == 1'b0, "R5 pin ignored in input role", sys_rst, 0);
      ext_low = 1'b0;
      repeat (3) @(negedge clk);

      // role writes
      write_role(0);
      chk(ctl_rd == 1'b0, "R2 write 0 in input role", ctl_rd, 0);
      write_role(1);
      chk(ctl_rd == 1'b1, "R2 role read", ctl_rd, 1);
      chk(pin_pullup == 1'b1, "R2 pullup", pin_pullup, 1);
      write_role(0);
      chk(ctl_rd == 1'b1, "R3 write 0 ignored", ctl_rd, 1);

      // each internal source with pin in reset role
      for (int s = 0; s < 3; s++) begin
         logic [5:0] exp;
         if (s == 0) begin pulse(0, 1, 0, 0, 0); exp = 6'b001000; end
         else if (s == 1) begin pulse(0, 0, 1, 0, 0); exp = 6'b010000; end
         else begin pulse(0, 0, 0, 0, 1); exp = 6'b100000; end
         measure(rn, dn);
         chk(rn == STRETCH, "R4 window length", rn, STRETCH);
         chk(dn == STRETCH, "R4 drive length", dn, STRETCH);
         chk(rst_status == exp, "R8 own pulse not logged / R7 source", rst_status, exp);
      end

      // allowed stop
      pulse(0, 0, 1, 1, 0);
      chk(sys_rst == 1'b0, "R7 allowed stop no reset", sys_rst, 0);
      repeat (3) @(negedge clk);
      chk(sys_rst == 1'b0, "R7 allowed stop later", sys_rst, 0);
      chk(rst_status == 6'b100000, "R7 status unchanged", rst_status, 32);

      // external pin low: sync latency
      @(negedge clk) ext_low = 1'b1;
      @(negedge clk) ext_low = 1'b0;
      @(negedge clk);
      chk(sys_rst == 1'b0, "R5 sync not yet", sys_rst, 0);
      @(negedge clk);
      chk(sys_rst == 1'b1, "R5 sync latency", sys_rst, 1);
      measure(rn, dn);
      chk(rn == STRETCH, "R5 window length", rn, STRETCH);
      chk(dn == STRETCH, "R5 drive length", dn, STRETCH);
      chk(rst_status == 6'b000100, "R5 pin bit", rst_status, 4);

      // requests during window ignored
      pulse(0, 1, 0, 0, 0);
      repeat (5) @(negedge clk);
      pulse(0, 0, 0, 0, 1);
      measure(rn, dn);
      chk(rst_status == 6'b001000, "R8 request during window ignored", rst_status, 8);
      begin
         int hi = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sys_rst) hi++;
         end
         chk(hi == 0, "R8 no second window", hi, 0);
      end

      // priority sweep of internal sources
      for (int m = 1; m < 16; m++) begin
         logic [5:0] exp;
         int edn;
         write_role(1);
         pulse(m[0], m[1], m[2], 0, m[3]);
         measure(rn, dn);
         exp = m[0] ? 6'b000010 : m[1] ? 6'b001000 : m[2] ? 6'b010000 : 6'b100000;
         edn = m[0] ? 0 : STRETCH;
         chk(rst_status == exp, "R6 priority", rst_status, exp);
         chk(dn == edn, "R9 drive vs low-voltage", dn, edn);
         chk(ctl_rd == !m[0], "R9 role after low-voltage / R3 kept", ctl_rd, !m[0]);
      end

      // pin coinciding with watchdog, then with low-voltage
      for (int c = 0; c < 2; c++) begin
         logic [5:0] exp;
         write_role(1);
         @(negedge clk) ext_low = 1'b1;
         @(negedge clk) ext_low = 1'b0;
         pulse(c == 1, c == 0, 0, 0, 0);
         measure(rn, dn);
         exp = (c == 0) ? 6'b000100 : 6'b000010;
         chk(rst_status == exp, "R6 pin priority", rst_status, exp);
      end

      // power-on clears role
      write_role(1);
      chk(ctl_rd == 1'b1, "R2 role before por", ctl_rd, 1);
      do_por();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule